// File: doc/BRIEF.md
# Bit Test-and-Clear Execution Unit

This unit performs one bit test-and-clear operation per request. In register mode it takes a 16-bit or 32-bit operand and a bit offset. It returns the operand with the chosen bit forced to 0 and reports the previous value of that bit as a carry flag. In memory mode the operand is a bit string in byte-addressed memory. The unit computes the byte that holds the target bit, reads it, writes it back with the bit cleared, and reports the previous bit value. Both the read and the write go over a one-byte request/acknowledge port, and the two accesses can be made atomic under a lock signal.

The offset comes either from a 32-bit register value or from a 5-bit immediate. A one-cycle `start` pulse in the idle state launches an operation, and `done` pulses for one cycle when it completes. The other arithmetic flags have no defined value after this operation, so the unit captures them at start and passes them through unchanged.

The controller has four states. IDLE waits for `start`. READ holds a read request until `mem_ack`. WRITE holds a write request until `mem_ack`. FINISH raises `done` for one cycle. The transitions are:
- IDLE to FINISH on `start` in register mode.
- IDLE to READ on `start` in memory mode.
- READ to WRITE on the read acknowledge.
- WRITE to FINISH on the write acknowledge.
- FINISH to IDLE unconditionally.

Top module: `bit_clear_unit`

## Requirements
- R1: `carry` reports the value the selected bit held before the operation, in both register and memory mode.
- R2: In register mode, `result` equals `reg_operand` with the selected bit set to 0 and every other bit of the 32-bit input unchanged. This includes bits 31:16 when `wide`=0.
- R3: In register mode, the selected bit index is the effective offset modulo 32 when `wide`=1 and modulo 16 when `wide`=0.
- R4: When `use_imm`=1, the effective offset is the 5-bit `imm_offset` zero-extended (0 to 31) and `reg_offset` is ignored. When `use_imm`=0, the effective offset is `reg_offset`, taken as signed in memory mode.
- R5: In memory mode, `mem_addr` equals `base_addr` plus the effective offset arithmetically shifted right by 3, modulo 2^32, and the bit index within the byte is the offset's bits 2:0 (bit 0 is the least significant bit of the byte).
- R6: The memory sequence runs in this order. First a read is presented (`mem_req`=1, `mem_we`=0) and held with a stable address until `mem_ack`. Next a write to the same address is presented (`mem_we`=1) with `mem_wdata` equal to the read byte with the selected bit cleared, and held until `mem_ack`. `done` then rises in the cycle after the write acknowledge. The write is issued even when the bit was already 0.
- R7: When `lock_req` is 1 at start, `mem_lock` is 1 in every cycle from the read request through the write acknowledge. It is 0 for an unlocked operation and 0 whenever `mem_req` is 0.
- R8: In register mode, `done` is 1 in the cycle after the `start` edge, and `done` is never high for two consecutive cycles.
- R9: `start` has no effect while an operation is in progress: no extra `done` and no change to the outcome.
- R10: `flags_out` equals the `flags_in` value captured at start, from the completion of the operation onward.
- R11: In memory mode, `result` at completion equals the written byte, zero-extended to 32 bits.
- R12: After reset, `done`, `mem_req`, `mem_lock`, `carry`, `result` and `flags_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation (sampled in IDLE only) |
| mem_mode | input | 1 | 1: memory bit string, 0: register operand |
| wide | input | 1 | Register width: 1 = 32 bits, 0 = 16 bits |
| use_imm | input | 1 | Offset source: 1 = immediate, 0 = register |
| lock_req | input | 1 | Request atomic read-modify-write |
| reg_operand | input | 32 | Register operand |
| reg_offset | input | 32 | Register bit offset (signed in memory mode) |
| imm_offset | input | 5 | Immediate bit offset 0 to 31 |
| base_addr | input | 32 | Byte address of bit 0 of the bit string |
| flags_in | input | 5 | Undefined-after-operation flags, passed through |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` during a read |
| mem_ack | input | 1 | Acknowledge of the current request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Cleared register value or zero-extended written byte |
| carry | output | 1 | Previous value of the selected bit |
| flags_out | output | 5 | Captured `flags_in` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_lock | output | 1 | Bus lock held over the read-modify-write |

## Verification
The hardest situation to reach is a memory sequence stretched by slow acknowledges while a stray `start` arrives mid-sequence. The bench holds `mem_ack` low for one to three cycles in each phase and pulses `start` with register-mode inputs during the read wait. It then confirms that the write, `done` and the carry belong only to the original operation. Offsets at the ends of the signed range, and a base address near the top of the address space, exercise the arithmetic shift and the wraparound. A second pass over the same bytes makes every targeted bit already 0, which proves that the write-back is still issued.

// File: rtl/bclr_pkg.sv
package bclr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } bclr_state_e;

    localparam int BYTE_BITS = 8;
    localparam int BYTE_IDX_W = 3;

endpackage

// File: rtl/bclr_reg_path.sv
module bclr_reg_path #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    localparam int SEL_W   = $clog2(DATA_W),
    localparam int NSEL_W  = $clog2(NARROW_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [SEL_W-1:0]  off_bits,
    input  logic              wide,
    output logic [DATA_W-1:0] cleared,
    output logic              old_bit
);

    logic [SEL_W-1:0]  idx;
    logic [DATA_W-1:0] mask;

    // Offset wraps by the operand width.
    always_comb begin
        if (wide) begin
            idx = off_bits;
        end else begin
            idx = {{(SEL_W-NSEL_W){1'b0}}, off_bits[NSEL_W-1:0]};
        end
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign mask[g] = (idx == SEL_W'(g));
    end

    assign old_bit = |(operand & mask);
    assign cleared = operand & ~mask;

endmodule

// File: rtl/bclr_addr_gen.sv
module bclr_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_idx
);

    logic signed [OFF_W-1:0] off_s;
    logic signed [OFF_W-1:0] byte_off;
    logic [ADDR_W-1:0]       delta;

    assign off_s    = offset;
    assign byte_off = off_s >>> 3;

    if (ADDR_W > OFF_W) begin : g_sext
        assign delta = {{(ADDR_W-OFF_W){byte_off[OFF_W-1]}}, byte_off};
    end else begin : g_trunc
        assign delta = byte_off[ADDR_W-1:0];
    end

    assign byte_addr = base + delta;
    assign bit_idx   = offset[2:0];

endmodule

// File: rtl/bclr_byte_merge.sv
module bclr_byte_merge
    import bclr_pkg::*;
(
    input  logic [BYTE_BITS-1:0]  rdata,
    input  logic [BYTE_IDX_W-1:0] bit_idx,
    output logic [BYTE_BITS-1:0]  cleared,
    output logic                  old_bit
);

    logic [BYTE_BITS-1:0] mask;

    for (genvar g = 0; g < BYTE_BITS; g++) begin : g_mask
        assign mask[g] = (bit_idx == BYTE_IDX_W'(g));
    end

    assign old_bit = |(rdata & mask);
    assign cleared = rdata & ~mask;

endmodule

// File: rtl/bit_clear_unit.sv
module bit_clear_unit
    import bclr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16,
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = 32,
    parameter int FLAG_W   = 5,
    localparam int SEL_W   = $clog2(DATA_W),
    localparam int IMM_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mem_mode,
    input  logic              wide,
    input  logic              use_imm,
    input  logic              lock_req,
    input  logic [DATA_W-1:0] reg_operand,
    input  logic [OFF_W-1:0]  reg_offset,
    input  logic [IMM_W-1:0]  imm_offset,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic [FLAG_W-1:0] flags_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_lock
);

    bclr_state_e state_q, state_d;

    logic [OFF_W-1:0]      off_eff;
    logic [DATA_W-1:0]     reg_cleared;
    logic                  reg_old;
    logic [ADDR_W-1:0]     calc_addr;
    logic [2:0]            calc_idx;
    logic [BYTE_BITS-1:0]  byte_cleared;
    logic                  byte_old;

    logic [ADDR_W-1:0]     addr_q;
    logic [2:0]            idx_q;
    logic [BYTE_BITS-1:0]  wdata_q;
    logic                  lock_q;
    logic [DATA_W-1:0]     result_q;
    logic                  carry_q;
    logic [FLAG_W-1:0]     flags_q;

    logic                  launch;

    // Effective offset: immediate is zero-extended.
    assign off_eff = use_imm ? {{(OFF_W-IMM_W){1'b0}}, imm_offset} : reg_offset;
    assign launch  = (state_q == ST_IDLE) && start;

    bclr_reg_path #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_reg_path (
        .operand  (reg_operand),
        .off_bits (off_eff[SEL_W-1:0]),
        .wide     (wide),
        .cleared  (reg_cleared),
        .old_bit  (reg_old)
    );

    bclr_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_addr_gen (
        .base      (base_addr),
        .offset    (off_eff),
        .byte_addr (calc_addr),
        .bit_idx   (calc_idx)
    );

    bclr_byte_merge u_byte_merge (
        .rdata   (mem_rdata),
        .bit_idx (idx_q),
        .cleared (byte_cleared),
        .old_bit (byte_old)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = mem_mode ? ST_READ : ST_FINISH;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Operand capture and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            idx_q    <= '0;
            wdata_q  <= '0;
            lock_q   <= 1'b0;
            result_q <= '0;
            carry_q  <= 1'b0;
            flags_q  <= '0;
        end else begin
            if (launch) begin
                flags_q <= flags_in;
                addr_q  <= calc_addr;
                idx_q   <= calc_idx;
                lock_q  <= mem_mode & lock_req;
                if (!mem_mode) begin
                    result_q <= reg_cleared;
                    carry_q  <= reg_old;
                end
            end
            if ((state_q == ST_READ) && mem_ack) begin
                carry_q <= byte_old;
                wdata_q <= byte_cleared;
            end
            if ((state_q == ST_WRITE) && mem_ack) begin
                result_q <= {{(DATA_W-BYTE_BITS){1'b0}}, wdata_q};
            end
        end
    end

    // Outputs
    always_comb begin
        done     = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_lock = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                done = 1'b0;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_lock = lock_q;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_lock = lock_q;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: done = 1'b0;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign result    = result_q;
    assign carry     = carry_q;
    assign flags_out = flags_q;

endmodule

// File: rtl/bclr_checker.sv
module bclr_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_mode,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr
);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_reg_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_mode && !mem_req && !done) |=> done);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    p_write_follows_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

    p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (done && !mem_req));

    p_lock_spans_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && mem_lock) |=> mem_lock);

    p_lock_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |-> mem_req);

    p_no_req_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

bind bit_clear_unit bclr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mem_mode (mem_mode),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_lock (mem_lock),
    .mem_addr (mem_addr)
);

// File: tb/bit_clear_unit_tb.sv
`timescale 1ns/1ps
module bit_clear_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_mode = 1'b0;
    logic        wide = 1'b0;
    logic        use_imm = 1'b0;
    logic        lock_req = 1'b0;
    logic [31:0] reg_operand = '0;
    logic [31:0] reg_offset = '0;
    logic [4:0]  imm_offset = '0;
    logic [31:0] base_addr = '0;
    logic [4:0]  flags_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        done;
    logic [31:0] result;
    logic        carry;
    logic [4:0]  flags_out;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_lock;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] bench_mem [256];

    always #2 clk = ~clk;

    bit_clear_unit u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .mem_mode (mem_mode),
        .wide (wide), .use_imm (use_imm), .lock_req (lock_req),
        .reg_operand (reg_operand), .reg_offset (reg_offset),
        .imm_offset (imm_offset), .base_addr (base_addr), .flags_in (flags_in),
        .mem_rdata (mem_rdata), .mem_ack (mem_ack), .done (done),
        .result (result), .carry (carry), .flags_out (flags_out),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_lock (mem_lock)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Register-mode operation: R1 R2 R3 R4 R8 R10
    task automatic reg_op(input logic [31:0] opnd, input logic [31:0] off,
                          input bit imm_sel, input bit wide_sel, input logic [4:0] fl);
        int unsigned eff;
        int unsigned k;
        logic [31:0] exp_res;
        eff = imm_sel ? int'(off[4:0]) : off;
        k = wide_sel ? (eff % 32) : (eff % 16);
        exp_res = opnd & ~(32'd1 << k);
        @(negedge clk);
        mem_mode = 1'b0; wide = wide_sel; use_imm = imm_sel;
        reg_operand = opnd; flags_in = fl;
        if (imm_sel) begin
            imm_offset = off[4:0];
            reg_offset = ~off;
        end else begin
            reg_offset = off;
            imm_offset = ~off[4:0];
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        flags_in = ~fl;
        chk("R8", "done one cycle after start", {31'd0, done}, 32'd1);
        chk("R2_R3", "cleared result", result, exp_res);
        chk("R1", "carry old bit", {31'd0, carry}, {31'd0, opnd[k]});
        chk("R10", "flags passed", {27'd0, flags_out}, {27'd0, fl});
        @(negedge clk);
        chk("R8", "done single pulse", {31'd0, done}, 32'd0);
    endtask

    // Memory-mode operation: R1 R4 R5 R6 R7 R9 R10 R11
    task automatic mem_op(input logic [31:0] base, input logic [31:0] off,
                          input bit imm_sel, input bit lk, input int dly,
                          input bit stray, input logic [4:0] fl);
        logic [31:0] eff;
        logic [31:0] exp_addr;
        logic [2:0]  idx;
        logic [7:0]  old_b;
        logic [7:0]  exp_w;
        eff = imm_sel ? {27'd0, off[4:0]} : off;
        exp_addr = base + 32'($signed(eff) >>> 3);
        idx = eff[2:0];
        old_b = bench_mem[exp_addr[7:0]];
        exp_w = old_b & ~(8'd1 << idx);
        @(negedge clk);
        mem_mode = 1'b1; use_imm = imm_sel; base_addr = base;
        lock_req = lk; flags_in = fl;
        if (imm_sel) begin
            imm_offset = off[4:0];
            reg_offset = 32'hDEAD_BEEF;
        end else begin
            reg_offset = off;
            imm_offset = 5'd13;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        flags_in = ~fl;
        lock_req = ~lk;
        chk("R6", "read request", {30'd0, mem_req, mem_we}, 32'd2);
        chk("R5", "byte address", mem_addr, exp_addr);
        chk("R7", "lock in read", {31'd0, mem_lock}, {31'd0, lk});
        for (int i = 0; i < dly; i++) begin
            if (stray && i == 0) begin
                start = 1'b1;
                mem_mode = 1'b0;
            end
            @(negedge clk);
            start = 1'b0;
            mem_mode = 1'b1;
            chk("R6", "read held", {30'd0, mem_req, mem_we}, 32'd2);
            chk("R9", "no done mid-sequence", {31'd0, done}, 32'd0);
        end
        mem_rdata = old_b;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        mem_rdata = 8'h00;
        chk("R6", "write request", {30'd0, mem_req, mem_we}, 32'd3);
        chk("R6", "write data cleared", {24'd0, mem_wdata}, {24'd0, exp_w});
        chk("R6", "write address", mem_addr, exp_addr);
        chk("R7", "lock in write", {31'd0, mem_lock}, {31'd0, lk});
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R6", "write held", {30'd0, mem_req, mem_we}, 32'd3);
        end
        bench_mem[exp_addr[7:0]] = mem_wdata;
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R6", "done after write ack", {31'd0, done}, 32'd1);
        chk("R1", "mem carry old bit", {31'd0, carry}, {31'd0, old_b[idx]});
        chk("R11", "mem result byte", result, {24'd0, exp_w});
        chk("R10", "mem flags passed", {27'd0, flags_out}, {27'd0, fl});
        chk("R7", "lock released", {30'd0, mem_req, mem_lock}, 32'd0);
        @(negedge clk);
        chk("R9", "single done", {31'd0, done}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bench_mem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "reset outputs",
            {done, mem_req, mem_lock, carry, flags_out, result[23:0]}, 32'd0);
        chk("R12", "reset result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "idle after reset", {29'd0, done, mem_req, mem_lock}, 32'd0);

        // R3 sweep: offsets 0..63, both widths, three operand patterns
        for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 3; p++) begin
                for (int o = 0; o < 64; o++) begin
                    logic [31:0] opnd;
                    opnd = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5C3_5A3C : 32'h0000_0000;
                    reg_op(opnd, 32'(o), 1'b0, w[0], 5'(o + p));
                end
            end
        end
        // R3 large and negative register offsets
        reg_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 5'h1F);
        reg_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 5'h0A);
        reg_op(32'h1234_F00F, 32'h8000_0003, 1'b0, 1'b1, 5'h05);
        reg_op(32'h1234_F00F, 32'h7FFF_FFF3, 1'b0, 1'b0, 5'h15);
        // R4 immediate offsets, register offset ignored
        for (int w = 0; w < 2; w++) begin
            for (int o = 0; o < 32; o++) begin
                reg_op(32'h6E6E_9191, 32'(o), 1'b1, w[0], 5'(o));
            end
        end

        // R5 R6 R7: signed register offsets around a base, two passes
        for (int pass = 0; pass < 2; pass++) begin
            for (int o = -48; o <= 48; o++) begin
                mem_op(32'h0000_0080, 32'(o), 1'b0, o[0], (o + 48) % 3,
                       ((o + 48) % 3 != 0) && o[1], 5'(o));
            end
        end
        // R4 immediate in memory mode
        for (int o = 0; o < 32; o++) begin
            mem_op(32'h0000_0040, 32'(o), 1'b1, 1'b1, o % 2, 1'b0, 5'(o));
        end
        // R5 extreme offsets and address wraparound
        mem_op(32'h0000_0010, 32'h7FFF_FFFF, 1'b0, 1'b1, 1, 1'b1, 5'h11);
        mem_op(32'h0000_0010, 32'h8000_0000, 1'b0, 1'b1, 2, 1'b0, 5'h12);
        mem_op(32'hFFFF_FFF8, 32'd64, 1'b0, 1'b0, 0, 1'b0, 5'h13);
        mem_op(32'h0000_0003, 32'hFFFF_FFE7, 1'b0, 1'b1, 3, 1'b1, 5'h14);
        // R6 write even when bit already 0 (same bit twice)
        mem_op(32'h0000_00A0, 32'd5, 1'b0, 1'b1, 1, 1'b0, 5'h01);
        mem_op(32'h0000_00A0, 32'd5, 1'b0, 1'b1, 1, 1'b0, 5'h02);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule